// File: doc/BRIEF.md
# Bus-Activity Gated Data Output Enable

This block sits in front of the data-bus drivers of a host-bus slave. It keeps those drivers tri-stated until it has evidence that a real host is attached. It watches three asynchronous host lines:

- the host clock;
- the read/not-write strobe;
- the active-low select.

Each line passes through a synchroniser clocked by a faster local clock. The block counts transitions on the clock line and on the read/write line, each in its own counter. It declares the bus qualified only when both counts have reached their thresholds and the select line has stayed high and quiet the whole time.

Once qualified, the block drives a data output enable only while a read is in progress: select low and read/write high. The qualified state holds until reset. It is dropped if the host clock stops toggling for a set number of local cycles, which returns the drivers to high impedance and starts qualification over. A select line left floating reads high through its pull-up, so an unconnected select never blocks qualification and never opens the drivers.

Top module: `bus_qual_gate`

## Requirements
- R1: After a synchronous reset, `qualified` and `data_oe` are both 0 and stay 0 until qualification completes.
- R2: Both rising and falling edges of the host clock count. `qualified` cannot rise until at least CLK_EDGES such edges have been seen since the last restart; one edge fewer leaves it 0.
- R3: `qualified` also needs at least RNW_EDGES edges on the read/write line, counted apart from the clock edges. Any surplus of clock edges does not make up a shortfall of read/write edges.
- R4: Before qualification, any edge on the select line clears both edge counts, so both thresholds must be met again in full after it.
- R5: `qualified` rises only while the synchronised select level is high (1 = idle). A select held low keeps the block unqualified whatever the activity on the other lines.
- R6: `data_oe` is 1 only when the block is qualified, select is low and read/write is high (1 = read). It is 0 during writes, while select is high, and at all times while unqualified.
- R7: Once set, `qualified` is not cleared by select or read/write activity; only reset or the clock timeout clears it.
- R8: After IDLE_CYCLES consecutive local cycles with no host clock edge, `qualified` and `data_oe` fall. Qualification then needs both full thresholds again.
- R9: The edge counts saturate at their thresholds and do not wrap. A clock edge count far above CLK_EDGES still qualifies once the read/write threshold is met.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock, faster than the host clock |
| rst | input | 1 | Synchronous active-high reset |
| host_clk_a | input | 1 | Asynchronous host bus clock |
| host_rnw_a | input | 1 | Asynchronous host read/not-write (1 = read) |
| host_sel_n_a | input | 1 | Asynchronous active-low select, idles high |
| qualified | output | 1 | Set while the host bus is judged genuine |
| data_oe | output | 1 | Registered data-bus output enable |

## Verification
The bench drives each threshold one edge short, to catch a counter compared with the wrong limit or an off-by-one that opens the drivers early. It drives a glitch on select between the clock and read/write bursts: a design that restarted only one counter, or none, would qualify there when it must not. It holds select low for a whole burst, which would expose a design that checks only for select edges and not for the select level. It pushes the clock count far past the width of its counter, so a wrapping counter would miss the threshold. It also lets the host clock go quiet long enough to expire, and then checks that a lone read/write burst cannot requalify a design whose counters were left saturated.

// File: rtl/bus_qual_pkg.sv
package bus_qual_pkg;

  typedef struct packed {
    logic sel_n;
    logic rnw;
    logic hclk;
  } host_sig_t;

  localparam host_sig_t HOST_IDLE = '{sel_n: 1'b1, rnw: 1'b1, hclk: 1'b0};

endpackage

// File: rtl/bqg_sync_edge.sv
module bqg_sync_edge #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] level,
  output logic [W-1:0] toggled
);

  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      last <= RST_VAL;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      last <= stg[STAGES-1];
    end
  end

  assign level   = stg[STAGES-1];
  assign toggled = stg[STAGES-1] ^ last;

endmodule

// File: rtl/bqg_edge_count.sv
module bqg_edge_count #(
  parameter  int LIMIT = 32,
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hit,
  output logic [CW-1:0] count,
  output logic          full
);

  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr)             count <= '0;
    else if (hit && count != TOP) count <= count + 1'b1;
  end

  assign full = (count == TOP);

  assert_sat_bound_R9: assert property (@(posedge clk) disable iff (rst)
    count <= TOP);
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (full && !clr) |=> full);

endmodule

// File: rtl/bqg_idle_timer.sv
module bqg_idle_timer #(
  parameter  int IDLE = 1024,
  localparam int TW   = $clog2(IDLE)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic kick,
  output logic expire
);

  localparam logic [TW-1:0] LAST = TW'(IDLE - 1);
  logic [TW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || !arm || kick) gap <= '0;
    else if (gap != LAST)    gap <= gap + 1'b1;
  end

  assign expire = arm && !kick && (gap == LAST);

  assert_expire_armed_R8: assert property (@(posedge clk) disable iff (rst)
    expire |-> $past(arm));

endmodule

// File: rtl/bus_qual_gate.sv
module bus_qual_gate
  import bus_qual_pkg::*;
#(
  parameter int CLK_EDGES   = 32,
  parameter int RNW_EDGES   = 32,
  parameter int IDLE_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic host_clk_a,
  input  logic host_rnw_a,
  input  logic host_sel_n_a,
  output logic qualified,
  output logic data_oe
);

  localparam int CCW = $clog2(CLK_EDGES + 1);
  localparam int RCW = $clog2(RNW_EDGES + 1);

  host_sig_t raw, lvl, tog;
  logic [CCW-1:0] clk_cnt;
  logic [RCW-1:0] rnw_cnt;
  logic           clk_full, rnw_full, expire, restart;

  assign raw = '{sel_n: host_sel_n_a, rnw: host_rnw_a, hclk: host_clk_a};

  bqg_sync_edge #(.W($bits(host_sig_t)), .STAGES(SYNC_STAGES), .RST_VAL(HOST_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_async(raw), .level(lvl), .toggled(tog)
  );

  assign restart = (!qualified && tog.sel_n) || expire;

  bqg_edge_count #(.LIMIT(CLK_EDGES)) u_clk_cnt (
    .clk(clk), .rst(rst), .clr(restart), .hit(tog.hclk), .count(clk_cnt), .full(clk_full)
  );

  bqg_edge_count #(.LIMIT(RNW_EDGES)) u_rnw_cnt (
    .clk(clk), .rst(rst), .clr(restart), .hit(tog.rnw), .count(rnw_cnt), .full(rnw_full)
  );

  bqg_idle_timer #(.IDLE(IDLE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .arm(qualified), .kick(tog.hclk), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      qualified <= 1'b0;
      data_oe   <= 1'b0;
    end else begin
      if (!qualified)
        qualified <= clk_full && rnw_full && lvl.sel_n && !tog.sel_n;
      else if (expire)
        qualified <= 1'b0;
      data_oe <= qualified && !expire && !lvl.sel_n && lvl.rnw;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!qualified && !data_oe));
  assert_rise_clk_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(qualified) |-> ($past(clk_cnt) == CCW'(CLK_EDGES)));
  assert_rise_rnw_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(qualified) |-> ($past(rnw_cnt) == RCW'(RNW_EDGES)));
  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (!qualified && tog.sel_n) |=> (clk_cnt == '0 && rnw_cnt == '0));
  assert_sel_high_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(qualified) |-> $past(lvl.sel_n));
  assert_oe_gate_R6: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ($past(qualified) && $past(lvl.rnw) && !$past(lvl.sel_n)));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (qualified && !expire) |=> qualified);
  assert_timeout_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(qualified) |-> $past(expire));

endmodule

// File: tb/bus_qual_gate_tb.sv
module bus_qual_gate_tb;

  localparam int CE = 8;
  localparam int RE = 6;
  localparam int IDLE = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hclk = 1'b0, rnw = 1'b1, sel_n = 1'b1;
  logic qualified, data_oe;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  bus_qual_gate #(.CLK_EDGES(CE), .RNW_EDGES(RE), .IDLE_CYCLES(IDLE)) u_dut (
    .clk(clk), .rst(rst), .host_clk_a(hclk), .host_rnw_a(rnw),
    .host_sel_n_a(sel_n), .qualified(qualified), .data_oe(data_oe)
  );

  // columns: clock edges, rnw edges, select mode (0 quiet, 1 glitch between bursts, 2 held low), expected qualified
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{CE,     RE,     0, 1},   // R2 R3 exact thresholds
    '{CE - 1, RE,     0, 0},   // R2 one clock edge short
    '{CE,     RE - 1, 0, 0},   // R3 one rnw edge short
    '{40,     RE - 1, 0, 0},   // R3 surplus clock edges do not substitute
    '{40,     RE,     0, 1},   // R9 far beyond counter width
    '{CE,     RE,     1, 0},   // R4 glitch restarts counts
    '{CE,     RE,     2, 0},   // R5 select held low
    '{0,      0,      0, 0}    // R1 no activity
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    hclk = 1'b0; rnw = 1'b1; sel_n = 1'b1; rst = 1'b1;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(3);
  endtask

  task automatic clk_edges(input int n);
    for (int i = 0; i < n; i++) begin hclk = ~hclk; wait_cyc(4); end
  endtask

  task automatic rnw_edges(input int n);
    for (int i = 0; i < n; i++) begin rnw = ~rnw; wait_cyc(4); end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 qualified after reset", qualified, 1'b0);
    chk("R1 data_oe after reset", data_oe, 1'b0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      if (VEC[v][2] == 2) begin sel_n = 1'b0; wait_cyc(4); end
      clk_edges(VEC[v][0]);
      if (VEC[v][2] == 1) begin
        sel_n = 1'b0; wait_cyc(4);
        sel_n = 1'b1; wait_cyc(4);
      end
      rnw_edges(VEC[v][1]);
      wait_cyc(4);
      chk($sformatf("R2/R3/R4/R5/R9 vector %0d", v), qualified, VEC[v][3] != 0);
      if (VEC[v][3] == 0) begin
        sel_n = 1'b0; rnw = 1'b1; wait_cyc(4);
        chk("R6 no drive while unqualified", data_oe, 1'b0);
      end
    end

    // R6 / R7 read gating once qualified
    do_reset();
    clk_edges(CE); rnw_edges(RE); wait_cyc(3);
    chk("R6 qualified before read", qualified, 1'b1);
    chk("R6 idle select no drive", data_oe, 1'b0);
    sel_n = 1'b0; wait_cyc(4);
    chk("R6 read drives", data_oe, 1'b1);
    rnw = 1'b0; wait_cyc(4);
    chk("R6 write no drive", data_oe, 1'b0);
    chk("R7 sticky through select", qualified, 1'b1);
    rnw = 1'b1; wait_cyc(4);
    chk("R6 read again drives", data_oe, 1'b1);
    sel_n = 1'b1; wait_cyc(4);
    chk("R6 deselect stops drive", data_oe, 1'b0);
    chk("R7 sticky after deselect", qualified, 1'b1);

    // R8 keep-alive, timeout, then requalify from scratch
    for (int k = 0; k < 5; k++) begin hclk = ~hclk; wait_cyc(40); end
    chk("R8 periodic clock keeps qualified", qualified, 1'b1);
    sel_n = 1'b0; wait_cyc(IDLE + 10);
    chk("R8 timeout clears qualified", qualified, 1'b0);
    chk("R8 timeout clears data_oe", data_oe, 1'b0);
    sel_n = 1'b1; wait_cyc(4);
    rnw_edges(RE); wait_cyc(4);
    chk("R8 rnw alone cannot requalify", qualified, 1'b0);
    clk_edges(CE); wait_cyc(4);
    chk("R8 full counts requalify", qualified, 1'b1);

    report();
  end

endmodule